// File: doc/BRIEF.md
# Cache Data SRAM Test Mode Controller

This block sits between the cache tag comparator and the memory controllers. In normal operation it passes the cache controller's hit, fill, castout and tag-write decisions through unchanged. In test mode it takes over those decisions so that software can size the cache data SRAM and test it directly. A programmable address window then stands in for the tag comparator. Any access that decodes inside the window is a hit that touches only the SRAM. Any access outside the window goes to main memory uncached.

The window size follows the cache-size setting. Its base is aligned to that size. The block also steers the SRAM bank enables and the low SRAM address line for one-bank and two-bank builds. During software sizing the bank setting may not match the fitted hardware. Every output is registered, so a decision appears on the clock edge after the processor cycle that causes it. The processor-side cacheable indication passes through the same register stage, and this mode does not change it.

Top module: `cache_sram_test_ctl`

## Requirements
- R1: Test mode is active only while testModeEn is 1 and cacheEn, cacheInit and freezeDir are all 0. Otherwise cacheHit follows tagHit, and lineFill, castout and tagWrite follow normFill, normCastout and normTagWr, each gated by cycValid.
- R2: While test mode is active, cacheHit equals the window decode and tagHit has no effect.
- R3: sizeSel codes 0, 1, 2, 3 and 4 give window sizes of 64K, 128K, 256K, 512K and 1M. Codes 5 to 7 behave as 1M. An access hits when cpuAddr[31:16+s] equals winBase[15:s], where s is the effective size code.
- R4: While test mode is active, lineFill, castout and tagWrite stay 0.
- R5: A test-mode access inside the window starts no DRAM cycle (dramGo=0) and gives dramWrEn=0, whatever the value of wrPolicy.
- R6: A test-mode access outside the window gives dramGo=1, dramWrEn=cycWrite and cacheable=0. Inside the window, cacheable is also 0.
- R7: In normal mode, a miss gives dramGo=1. A write hit gives dramGo=dramWrEn=1 only when wrPolicy=1 (write-through). A read hit gives dramGo=0. cacheable equals cycValid.
- R8: With dualBank=0, bank0En equals cacheHit, bank1En is 0, and sramA2 equals cpuAddr[2].
- R9: With dualBank=1, bank0En is cacheHit with cpuAddr[2]=0 (bytes 0-3 and 8-11 of a 16-byte line), bank1En is cacheHit with cpuAddr[2]=1 (bytes 4-7 and 12-15), and sramA2 equals cpuAddr[3].
- R10: kenOut equals kenIn of the previous cycle in every mode.
- R11: All outputs are registered with one cycle of latency and are 0 during reset. A cycle with cycValid=0 yields no hit, fill, castout, tag write, DRAM start or bank enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuAddr | input | 32 | Processor byte address |
| cycValid | input | 1 | A memory cycle is presented this clock |
| cycWrite | input | 1 | The cycle is a write |
| testModeEn | input | 1 | Data SRAM test mode request |
| cacheEn | input | 1 | Cache enable setting |
| cacheInit | input | 1 | Cache initialise setting |
| freezeDir | input | 1 | Freeze-directory setting |
| wrPolicy | input | 1 | 1 = write-through, 0 = write-back |
| sizeSel | input | 3 | Cache size code (also the window size) |
| dualBank | input | 1 | 1 = two SRAM banks selected |
| winBase | input | 16 | Window base, address bits 31:16 |
| tagHit | input | 1 | Tag comparator result |
| normFill | input | 1 | Normal line-fill request |
| normCastout | input | 1 | Normal castout request |
| normTagWr | input | 1 | Normal tag update request |
| kenIn | input | 1 | Cacheable indication toward the processor |
| cacheHit | output | 1 | Hit to SRAM and DRAM controllers |
| lineFill | output | 1 | Start a line fill |
| castout | output | 1 | Start a castout |
| tagWrite | output | 1 | Write the tag RAM |
| dramGo | output | 1 | Start a DRAM or expansion-bus cycle |
| dramWrEn | output | 1 | The DRAM cycle writes |
| cacheable | output | 1 | The access may be cached |
| bank0En | output | 1 | SRAM bank 0 enable |
| bank1En | output | 1 | SRAM bank 1 enable |
| sramA2 | output | 1 | Low SRAM address line |
| kenOut | output | 1 | Registered kenIn |

## Verification
The hardest case to reach is a write that the tag comparator reports as a hit while write-through is selected, but that falls outside the test window. A wrong design could take its DRAM decision from tagHit instead of the window. The stimulus sets tagHit=1 and wrPolicy=1 together with every window case, places addresses one granule on each side of the window edges for several size codes, and uses the size codes above 1M. The two bank settings are checked at the same address so that the byte-lane steering differences can be seen.

// File: rtl/cache_tm_pkg.sv
package cache_tm_pkg;
  // Decisions the control half hands to the datapath for registering.
  typedef struct packed {
    logic hit;
    logic fill;
    logic cast;
    logic tagWr;
    logic dramGo;
    logic dramWr;
    logic cacheable;
  } tmStrobes_t;
endpackage

// File: rtl/tm_control.sv
module tm_control
  import cache_tm_pkg::*;
(
  input  logic       cycValid,
  input  logic       cycWrite,
  input  logic       testModeEn,
  input  logic       cacheEn,
  input  logic       cacheInit,
  input  logic       freezeDir,
  input  logic       wrPolicy,
  input  logic       tagHit,
  input  logic       normFill,
  input  logic       normCastout,
  input  logic       normTagWr,
  input  logic       winHit,
  output tmStrobes_t strobes
);
  logic testActive;

  // Test mode is honoured only with the cache otherwise quiesced.
  assign testActive = testModeEn & ~cacheEn & ~cacheInit & ~freezeDir;

  always_comb begin
    strobes = '0;
    if (cycValid) begin
      if (testActive) begin
        strobes.hit       = winHit;
        strobes.dramGo    = ~winHit;
        strobes.dramWr    = ~winHit & cycWrite;
        strobes.cacheable = 1'b0;
      end else begin
        strobes.hit       = tagHit;
        strobes.fill      = normFill;
        strobes.cast      = normCastout;
        strobes.tagWr     = normTagWr;
        strobes.dramGo    = ~tagHit | (cycWrite & wrPolicy);
        strobes.dramWr    = cycWrite & (~tagHit | wrPolicy);
        strobes.cacheable = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tm_datapath.sv
module tm_datapath
  import cache_tm_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int WIN_LSB  = 16,
  parameter int SIZE_W   = 3,
  parameter int MAX_CODE = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [ADDR_W-1:0]         cpuAddr,
  input  logic [ADDR_W-WIN_LSB-1:0] winBase,
  input  logic [SIZE_W-1:0]         sizeSel,
  input  logic                      dualBank,
  input  logic                      kenIn,
  input  tmStrobes_t                strobes,
  output logic                      winHit,
  output logic                      cacheHit,
  output logic                      lineFill,
  output logic                      castout,
  output logic                      tagWrite,
  output logic                      dramGo,
  output logic                      dramWrEn,
  output logic                      cacheable,
  output logic                      bank0En,
  output logic                      bank1En,
  output logic                      sramA2,
  output logic                      kenOut
);
  localparam int FIELD_W = ADDR_W - WIN_LSB;

  logic [SIZE_W-1:0]  effSize;
  logic [FIELD_W-1:0] keepMask;
  logic [FIELD_W-1:0] addrField;
  logic               lane0, lane1, nextA2;
  logic               unusedAddr;

  assign effSize   = (sizeSel > SIZE_W'(MAX_CODE)) ? SIZE_W'(MAX_CODE) : sizeSel;
  assign addrField = cpuAddr[ADDR_W-1:WIN_LSB];
  assign unusedAddr = ^{cpuAddr[WIN_LSB-1:4], cpuAddr[1:0]};

  // Bits below the window size are don't-care in the base compare.
  for (genvar i = 0; i < FIELD_W; i++) begin : g_mask
    localparam logic [7:0] IDX = 8'(i);
    assign keepMask[i] = (IDX >= {{(8-SIZE_W){1'b0}}, effSize});
  end

  assign winHit = ((addrField ^ winBase) & keepMask) == '0;

  // Byte-lane steering of the SRAM banks.
  always_comb begin
    if (dualBank) begin
      lane0  = strobes.hit & ~cpuAddr[2];
      lane1  = strobes.hit &  cpuAddr[2];
      nextA2 = cpuAddr[3];
    end else begin
      lane0  = strobes.hit;
      lane1  = 1'b0;
      nextA2 = cpuAddr[2];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cacheHit  <= 1'b0;
      lineFill  <= 1'b0;
      castout   <= 1'b0;
      tagWrite  <= 1'b0;
      dramGo    <= 1'b0;
      dramWrEn  <= 1'b0;
      cacheable <= 1'b0;
      bank0En   <= 1'b0;
      bank1En   <= 1'b0;
      sramA2    <= 1'b0;
      kenOut    <= 1'b0;
    end else begin
      cacheHit  <= strobes.hit;
      lineFill  <= strobes.fill;
      castout   <= strobes.cast;
      tagWrite  <= strobes.tagWr;
      dramGo    <= strobes.dramGo;
      dramWrEn  <= strobes.dramWr;
      cacheable <= strobes.cacheable;
      bank0En   <= lane0;
      bank1En   <= lane1;
      sramA2    <= nextA2;
      kenOut    <= kenIn;
    end
  end
endmodule

// File: rtl/cache_sram_test_ctl.sv
module cache_sram_test_ctl
  import cache_tm_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int WIN_LSB  = 16,
  parameter int SIZE_W   = 3,
  parameter int MAX_CODE = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [ADDR_W-1:0]         cpuAddr,
  input  logic                      cycValid,
  input  logic                      cycWrite,
  input  logic                      testModeEn,
  input  logic                      cacheEn,
  input  logic                      cacheInit,
  input  logic                      freezeDir,
  input  logic                      wrPolicy,
  input  logic [SIZE_W-1:0]         sizeSel,
  input  logic                      dualBank,
  input  logic [ADDR_W-WIN_LSB-1:0] winBase,
  input  logic                      tagHit,
  input  logic                      normFill,
  input  logic                      normCastout,
  input  logic                      normTagWr,
  input  logic                      kenIn,
  output logic                      cacheHit,
  output logic                      lineFill,
  output logic                      castout,
  output logic                      tagWrite,
  output logic                      dramGo,
  output logic                      dramWrEn,
  output logic                      cacheable,
  output logic                      bank0En,
  output logic                      bank1En,
  output logic                      sramA2,
  output logic                      kenOut
);
  tmStrobes_t strobes;
  logic       winHit;

  tm_control u_ctl (
    .cycValid, .cycWrite, .testModeEn, .cacheEn, .cacheInit, .freezeDir,
    .wrPolicy, .tagHit, .normFill, .normCastout, .normTagWr,
    .winHit, .strobes
  );

  tm_datapath #(
    .ADDR_W(ADDR_W), .WIN_LSB(WIN_LSB), .SIZE_W(SIZE_W), .MAX_CODE(MAX_CODE)
  ) u_dp (
    .clk, .rstN, .cpuAddr, .winBase, .sizeSel, .dualBank, .kenIn, .strobes,
    .winHit, .cacheHit, .lineFill, .castout, .tagWrite, .dramGo, .dramWrEn,
    .cacheable, .bank0En, .bank1En, .sramA2, .kenOut
  );
endmodule

// File: rtl/tm_checker.sv
module tm_checker (
  input logic clk,
  input logic rstN,
  input logic cycValid,
  input logic dualBank,
  input logic testModeEn,
  input logic cacheEn,
  input logic cacheInit,
  input logic freezeDir,
  input logic kenIn,
  input logic cacheHit,
  input logic lineFill,
  input logic castout,
  input logic tagWrite,
  input logic dramGo,
  input logic dramWrEn,
  input logic bank0En,
  input logic bank1En,
  input logic kenOut
);
  logic modeOk;
  assign modeOk = testModeEn & ~cacheEn & ~cacheInit & ~freezeDir;

  a_r4_no_fill_cast_tag: assert property (@(posedge clk) disable iff (!rstN)
    modeOk |=> (!lineFill && !castout && !tagWrite));

  a_r5_hit_stays_off_dram: assert property (@(posedge clk) disable iff (!rstN)
    (modeOk && cycValid) |=> (!cacheHit || (!dramGo && !dramWrEn)));

  a_r8_single_bank_one_lane: assert property (@(posedge clk) disable iff (!rstN)
    (!dualBank && cycValid) |=> !bank1En);

  a_r10_ken_follows: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (kenOut == $past(kenIn)));

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !cycValid |=> (!cacheHit && !lineFill && !dramGo && !bank0En && !bank1En));
endmodule

bind cache_sram_test_ctl tm_checker u_chk (.*);

// File: tb/tb_cache_sram_test_ctl.sv
`timescale 1ns/1ps
module tb_cache_sram_test_ctl;
  logic clk = 1'b0, rstN = 1'b0;
  logic [31:0] cpuAddr = '0;
  logic cycValid = 0, cycWrite = 0, testModeEn = 0, cacheEn = 0, cacheInit = 0;
  logic freezeDir = 0, wrPolicy = 0, dualBank = 0, tagHit = 0;
  logic normFill = 0, normCastout = 0, normTagWr = 0, kenIn = 0;
  logic [2:0]  sizeSel = '0;
  logic [15:0] winBase = '0;
  logic cacheHit, lineFill, castout, tagWrite, dramGo, dramWrEn, cacheable;
  logic bank0En, bank1En, sramA2, kenOut;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  cache_sram_test_ctl dut (.*);

  typedef struct packed {
    logic [31:0] addr;
    logic        wr;
    logic [2:0]  size;
    logic [15:0] base;
    logic        dual;
    logic        tag;
    logic [7:0]  exp; // {hit,fill,cast,tagWr,dramGo,dramWr,bank0,bank1}
  } vec_t;

  localparam int NV = 9;
  localparam vec_t TBL [NV] = '{
    '{32'h0008_0000, 1'b0, 3'd3, 16'h0008, 1'b0, 1'b0, 8'b1000_0010},
    '{32'h000F_FFF4, 1'b1, 3'd3, 16'h0008, 1'b1, 1'b0, 8'b1000_0001},
    '{32'h0010_0000, 1'b1, 3'd3, 16'h0008, 1'b0, 1'b1, 8'b0000_1100},
    '{32'h0007_FFFC, 1'b0, 3'd3, 16'h0008, 1'b0, 1'b1, 8'b0000_1000},
    '{32'h001A_0008, 1'b1, 3'd4, 16'h0010, 1'b1, 1'b1, 8'b1000_0010},
    '{32'h0003_1230, 1'b0, 3'd0, 16'h0003, 1'b0, 1'b0, 8'b1000_0010},
    '{32'h0002_1230, 1'b0, 3'd0, 16'h0003, 1'b0, 1'b1, 8'b0000_1000},
    '{32'h0007_0004, 1'b1, 3'd2, 16'h0004, 1'b1, 1'b1, 8'b1000_0001},
    '{32'h001F_0000, 1'b0, 3'd7, 16'h0010, 1'b0, 1'b1, 8'b1000_0010}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] outVec();
    return {cacheHit, lineFill, castout, tagWrite, dramGo, dramWrEn, bank0En, bank1En};
  endfunction

  // Registered outputs: sample 1 ns after the edge that captures the inputs.
  task automatic tick();
    @(posedge clk); #1;
  endtask

  initial begin : watchdog
    #200000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    kenIn = 1; tagHit = 1; cycValid = 1; normFill = 1;
    tick(); tick();
    // R11: reset state
    chk("R11 reset outputs", {21'b0, outVec(), cacheable, sramA2, kenOut}, 32'h0);
    rstN = 1;

    // R2 R3 R4 R5 R6 R8 R9: table walk in active test mode with write-through set
    testModeEn = 1; wrPolicy = 1; normCastout = 1; normTagWr = 1;
    for (int i = 0; i < NV; i++) begin
      cpuAddr = TBL[i].addr; cycWrite = TBL[i].wr; sizeSel = TBL[i].size;
      winBase = TBL[i].base; dualBank = TBL[i].dual; tagHit = TBL[i].tag;
      tick();
      chk($sformatf("R2 R3 R4 R5 R6 row %0d", i), {24'b0, outVec()}, {24'b0, TBL[i].exp});
      chk("R6 cacheable low in test mode", {31'b0, cacheable}, 32'h0);
    end

    // R8 vs R9: low SRAM address line selection at address ...4 / ...8
    sizeSel = 3'd3; winBase = 16'h0008; cpuAddr = 32'h0008_0008; dualBank = 0;
    tick(); chk("R8 sramA2 single bank", {31'b0, sramA2}, 32'h0);
    dualBank = 1;
    tick(); chk("R9 sramA2 dual bank", {31'b0, sramA2}, 32'h1);
    chk("R9 bank0 for bytes 8-11", {30'b0, bank0En, bank1En}, 32'h2);

    // R1: cacheEn set disables test mode -> pass-through of normal decisions
    cacheEn = 1; tagHit = 1; cycWrite = 0; cpuAddr = 32'h0030_0000;
    tick();
    chk("R1 normal pass-through", {24'b0, outVec()}, {24'b0, 8'b1111_0010});
    chk("R7 cacheable in normal mode", {31'b0, cacheable}, 32'h1);
    cacheEn = 0; freezeDir = 1; tagHit = 0;
    tick();
    chk("R1 freezeDir blocks test mode", {31'b0, cacheHit}, 32'h0);
    freezeDir = 0; cacheInit = 1; cpuAddr = 32'h0008_0000;
    tick();
    chk("R1 cacheInit blocks test mode", {29'b0, cacheHit, lineFill, dramGo}, 32'h3);
    cacheInit = 0;

    // R7: normal write hit with write-back vs write-through
    testModeEn = 0; tagHit = 1; cycWrite = 1; wrPolicy = 0;
    tick(); chk("R7 write-back hit", {30'b0, dramGo, dramWrEn}, 32'h0);
    wrPolicy = 1;
    tick(); chk("R7 write-through hit", {30'b0, dramGo, dramWrEn}, 32'h3);
    tagHit = 0; cycWrite = 0;
    tick(); chk("R7 read miss", {30'b0, dramGo, dramWrEn}, 32'h2);

    // R10: kenOut follows kenIn one cycle later, both modes
    kenIn = 0; tick(); chk("R10 ken low", {31'b0, kenOut}, 32'h0);
    testModeEn = 1; kenIn = 1; tick(); chk("R10 ken high in test mode", {31'b0, kenOut}, 32'h1);

    // R11: idle cycle gives nothing
    cycValid = 0; cycWrite = 1; tick();
    chk("R11 idle quiet", {24'b0, outVec()}, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule